// File: doc/BRIEF.md
# Sequence-Locked Watchdog Timer

This peripheral guards a system against software that stops making progress. A fixed divide-by-four prescaler paces a 24-bit down-counter. Software keeps the system alive by writing a two-byte unlock pattern to the kick register. That pattern reloads the counter from a programmable reload constant. If the counter runs down to zero once the watchdog is live, a sticky timeout flag is raised and, if reset generation is selected, a one-clock system reset request is issued.

Software sees four word-addressed registers on a simple strobe bus: mode, reload constant, kick, and live count. Turning the watchdog on cannot be undone by software. The watchdog only starts counting after the first correct unlock pattern that follows the enable. While the watchdog is on, a broken unlock pattern requests a reset at once, so stray writes cannot quietly keep a hung system alive. Reads return data one clock after the read strobe.

Top module: `wdog_feedlock`

## Requirements
- R1: After reset, `rst_req` and `timeout_flag` are 0. The mode register (word address 0) reads 0, and both the reload register (word address 1) and the live count (word address 3) read 0xFF.
- R2: A write to the reload register keeps only bits 23:0, and any value below 0xFF is stored as 0xFF. Reading it back returns the stored value.
- R3: Writing the reload register does not change the live count. The new constant reaches the counter only at the next accepted kick.
- R4: A kick is a write of 0xAA followed by a write of 0x55 to the kick register (word address 2), compared on data bits 7:0. Completing it loads the live count from the reload register and restarts the prescaler phase.
- R5: A read or write of any register other than the kick register, made between the 0xAA and 0x55 writes, cancels the pending kick. The 0x55 that follows is then ignored and the count does not reload.
- R6: While mode bit 0 (enable) is 0, the counter never decrements, and malformed kick sequences never raise `rst_req`.
- R7: Mode bit 0, once written to 1, reads back 1 until system reset, even after a write of 0.
- R8: With enable set but no accepted kick since then, the live count holds and `rst_req` stays low.
- R9: Once live, the count decrements by one every 4 clocks. The first step lands 4 clocks after the kick's completing write.
- R10: When the live count steps from 1 to 0, `timeout_flag` rises in that cycle and stays set, and the counter rests at 0. If mode bit 1 (reset enable) is set, `rst_req` is high for exactly that one cycle, reload×4 clocks after the kick.
- R11: With mode bit 1 clear, reaching zero sets `timeout_flag` but never asserts `rst_req`.
- R12: While enable is set, a write of 0xAA to the kick register followed by any other kick byte than 0x55 (including a second 0xAA) raises `rst_req` for one cycle right after that write, whatever mode bit 1 holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Word address: 0 mode, 1 reload, 2 kick, 3 live count |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| rst_req | output | 1 | One-cycle system reset request |
| timeout_flag | output | 1 | Sticky expiry indication |

## Verification
The bench uses the default parameters: a 24-bit counter, a prescale of 4 and a floor of 0xFF. With these values the shortest timeout is only 1020 clocks. This makes it practical to check a complete countdown to the exact cycle, and also a second countdown with reset generation turned off. The 24-bit width also makes the truncation of the upper write bits in the reload register visible, and with the small floor the clamp can be tested using an ordinary write.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_MODE   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_KICK   = 2'd2,
    REG_LIVE   = 2'd3
  } reg_sel_e;

  localparam int unsigned MODE_EN_BIT  = 0;
  localparam int unsigned MODE_RST_BIT = 1;

  localparam logic [7:0] KICK_OPEN  = 8'hAA;
  localparam logic [7:0] KICK_CLOSE = 8'h55;

  function automatic logic is_open_byte(input logic [7:0] b);
    return b == KICK_OPEN;
  endfunction

  function automatic logic is_close_byte(input logic [7:0] b);
    return b == KICK_CLOSE;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] phase_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              phase_q <= '0;
        else if (restart)        phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                     phase_q <= phase_q + 1'b1;
      end

      assign tick = (phase_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdog_kick_seq.sv
module wdog_kick_seq
  import wdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wbyte,
  output logic              kick_ok,
  output logic              kick_bad,
  output logic              pending
);
  logic pend_q;
  logic hit_kick;
  logic other_access;

  always_comb begin
    hit_kick     = wr_en && (addr == REG_KICK);
    other_access = (wr_en || rd_en) && (addr != REG_KICK);
    kick_ok      = pend_q && hit_kick && is_close_byte(wbyte);
    kick_bad     = pend_q && hit_kick && !is_close_byte(wbyte);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pend_q <= 1'b0;
    else if (hit_kick)     pend_q <= !pend_q && is_open_byte(wbyte);
    else if (other_access) pend_q <= 1'b0;
  end

  assign pending = pend_q;
endmodule

// File: rtl/wdog_downcount.sv
module wdog_downcount #(
  parameter int unsigned CW      = 24,
  parameter int unsigned RST_VAL = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          load,
  input  logic          arm,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          armed,
  output logic          expire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic          step;

  always_comb begin
    step   = armed_q && tick && !load && (cnt_q != '0);
    expire = step && (cnt_q == ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(RST_VAL);
      armed_q <= 1'b0;
    end else begin
      if (load)      cnt_q <= load_val;
      else if (step) cnt_q <= cnt_q - ONE;
      if (arm)       armed_q <= 1'b1;
    end
  end

  assign count = cnt_q;
  assign armed = armed_q;
endmodule

// File: rtl/wdog_feedlock.sv
module wdog_feedlock
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned PRESCALE   = 4,
  parameter int unsigned MIN_RELOAD = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              rst_req,
  output logic              timeout_flag
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

  function automatic logic [CNT_W-1:0] clamp_reload(input logic [BUS_W-1:0] v);
    logic [CNT_W-1:0] t;
    t = v[CNT_W-1:0];
    return (t < FLOOR) ? FLOOR : t;
  endfunction

  logic             en_q;
  logic             rsten_q;
  logic [CNT_W-1:0] reload_q;
  logic [BUS_W-1:0] rdata_q;
  logic             rst_req_q;
  logic             flag_q;

  logic             tick;
  logic             kick_ok;
  logic             kick_bad;
  logic             kick_pending;
  logic             expire;
  logic             armed;
  logic [CNT_W-1:0] live_cnt;
  logic             bad_hit;
  logic             wr_mode;
  logic             wr_reload;

  assign wr_mode   = wr_en && (addr == REG_MODE);
  assign wr_reload = wr_en && (addr == REG_RELOAD);
  assign bad_hit   = kick_bad && en_q;

  wdog_prescale #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (kick_ok),
    .tick    (tick)
  );

  wdog_kick_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wbyte    (wdata[7:0]),
    .kick_ok  (kick_ok),
    .kick_bad (kick_bad),
    .pending  (kick_pending)
  );

  wdog_downcount #(.CW(CNT_W), .RST_VAL(MIN_RELOAD)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (kick_ok),
    .arm      (kick_ok && en_q),
    .load_val (reload_q),
    .count    (live_cnt),
    .armed    (armed),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rsten_q  <= 1'b0;
      reload_q <= FLOOR;
    end else begin
      if (wr_mode) begin
        en_q    <= en_q | wdata[MODE_EN_BIT];
        rsten_q <= wdata[MODE_RST_BIT];
      end
      if (wr_reload) reload_q <= clamp_reload(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      unique case (addr)
        REG_MODE:   rdata_q <= BUS_W'({rsten_q, en_q});
        REG_RELOAD: rdata_q <= BUS_W'(reload_q);
        REG_LIVE:   rdata_q <= BUS_W'(live_cnt);
        default:    rdata_q <= '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      rst_req_q <= (expire && rsten_q) || bad_hit;
      flag_q    <= flag_q || expire;
    end
  end

  assign rdata        = rdata_q;
  assign rst_req      = rst_req_q;
  assign timeout_flag = flag_q;
endmodule

// File: rtl/wdog_feedlock_chk.sv
module wdog_feedlock_chk #(
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned MIN_RELOAD = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             rst_en,
  input logic             armed,
  input logic             tick,
  input logic             kick_ok,
  input logic             kick_bad,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload,
  input logic             rst_req,
  input logic             timeout_flag
);
  localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_RELOAD);

  a_r2_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
    reload >= FLOOR);

  a_r4_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> (cnt == $past(reload)));

  a_r6_off_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !rst_req);

  a_r7_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> en);

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_ok && !(armed && tick)) |=> $stable(cnt));

  a_r9_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && tick && !kick_ok && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1)));

  a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_flag |=> timeout_flag);

  a_r10_flag_needs_armed: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_flag) |-> $past(armed));

  a_r11_no_reset_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!rst_en && !(kick_bad && en)) |=> !rst_req);

  a_r12_bad_kick_resets: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_bad && en) |=> rst_req);
endmodule

bind wdog_feedlock wdog_feedlock_chk #(.CNT_W(CNT_W), .MIN_RELOAD(MIN_RELOAD)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .en           (en_q),
  .rst_en       (rsten_q),
  .armed        (armed),
  .tick         (tick),
  .kick_ok      (kick_ok),
  .kick_bad     (kick_bad),
  .cnt          (live_cnt),
  .reload       (reload_q),
  .rst_req      (rst_req),
  .timeout_flag (timeout_flag)
);

// File: tb/wdog_feedlock_tb.sv
module wdog_feedlock_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        rst_req;
  logic        timeout_flag;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;
  logic rd_q = 1'b0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  always #2.5 clk = ~clk;

  wdog_feedlock u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .rst_req      (rst_req),
    .timeout_flag (timeout_flag)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) if (rst_req) pulses++;

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_q) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "SB_EMPTY", rdata, 32'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rdata == e.exp, e.tag, rdata, e.exp);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.exp = exp; e.tag = tag;
    sbq.push_back(e);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic kick();
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
  endtask

  task automatic sys_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    pulses = 0;
  endtask

  initial begin
    repeat (100000) @(negedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL WATCHDOG actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    sys_reset();

    // R1 reset state
    chk(rst_req == 1'b0, "R1 rst_req", 32'(rst_req), 32'h0);
    chk(timeout_flag == 1'b0, "R1 flag", 32'(timeout_flag), 32'h0);
    rd_expect(2'd0, 32'h0, "R1 mode");
    rd_expect(2'd1, 32'hFF, "R1 reload");
    rd_expect(2'd3, 32'hFF, "R1 live");

    // R2 clamp and truncation
    wr(2'd1, 32'h10);
    rd_expect(2'd1, 32'hFF, "R2 clamp");
    wr(2'd1, 32'hABFF_FFFF);
    rd_expect(2'd1, 32'hFF_FFFF, "R2 truncate");
    wr(2'd1, 32'hAB00_1234);
    rd_expect(2'd1, 32'h1234, "R2 store");
    // R3 live count untouched until a kick
    rd_expect(2'd3, 32'hFF, "R3 no early load");
    kick();
    rd_expect(2'd3, 32'h1234, "R4 kick reload");
    // R6 disabled: no decrement
    repeat (40) @(negedge clk);
    rd_expect(2'd3, 32'h1234, "R6 hold when off");

    // R5 abort by another access
    wr(2'd1, 32'h300);
    wr(2'd2, 32'hAA);
    rd_expect(2'd0, 32'h0, "R5 mode read");
    wr(2'd2, 32'h55);
    rd_expect(2'd3, 32'h1234, "R5 aborted");
    // R6 malformed kick while off
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h77);
    @(negedge clk);
    chk(pulses == 0, "R6 no reset off", 32'(pulses), 32'h0);

    // R7 sticky enable, reset generation off
    wr(2'd0, 32'h1);
    wr(2'd0, 32'h0);
    rd_expect(2'd0, 32'h1, "R7 sticky");
    // R8 enabled, not fed yet
    repeat (60) @(negedge clk);
    rd_expect(2'd3, 32'h1234, "R8 hold unarmed");
    chk(pulses == 0, "R8 no reset", 32'(pulses), 32'h0);

    // R9 step pacing
    wr(2'd1, 32'h100);
    kick();
    repeat (13) @(negedge clk);
    rd_expect(2'd3, 32'hFD, "R9 three steps");
    // R11 expiry with reset generation off
    repeat (1100) @(negedge clk);
    chk(timeout_flag == 1'b1, "R11 flag set", 32'(timeout_flag), 32'h1);
    chk(pulses == 0, "R11 no rst_req", 32'(pulses), 32'h0);
    rd_expect(2'd3, 32'h0, "R10 rests at zero");

    // R10 exact timing with reset generation on
    sys_reset();
    wr(2'd0, 32'h3);
    kick();
    repeat (4 * 255 - 1) @(negedge clk);
    chk(rst_req == 1'b0, "R10 early", 32'(rst_req), 32'h0);
    chk(timeout_flag == 1'b0, "R10 flag early", 32'(timeout_flag), 32'h0);
    @(negedge clk);
    chk(rst_req == 1'b1, "R10 pulse", 32'(rst_req), 32'h1);
    chk(timeout_flag == 1'b1, "R10 flag", 32'(timeout_flag), 32'h1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R10 one cycle", 32'(rst_req), 32'h0);
    repeat (20) @(negedge clk);
    chk(timeout_flag == 1'b1, "R10 flag sticky", 32'(timeout_flag), 32'h1);

    // R12 bad kick while enabled, reset generation off
    sys_reset();
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h33);
    chk(rst_req == 1'b1, "R12 bad byte", 32'(rst_req), 32'h1);
    @(negedge clk);
    chk(rst_req == 1'b0, "R12 one cycle", 32'(rst_req), 32'h0);
    chk(timeout_flag == 1'b0, "R12 no flag", 32'(timeout_flag), 32'h0);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'hAA);
    chk(rst_req == 1'b1, "R12 double open", 32'(rst_req), 32'h1);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule